// File: doc/BRIEF.md
# Converter Mode and Ready Sequencer

This block is the control state machine behind the register port of a sigma-delta converter. When the mode register is written, it takes a 3-bit operating mode, a 4-bit update-rate code and a power-switch request. It counts conversion periods from a clock-enable tick. From the mode and the count it produces the ready and error status bits, a strobe that loads a conversion result into the data register, and a strobe that writes a calibration coefficient. It also reports the mode currently in force.

The length of a conversion period, in ticks, comes from a parameter table with one entry per rate code. The first result after a restart needs two periods. Each later result in continuous mode needs one period. A calibration runs for two or four periods and then leaves the block in idle. The overrange and underrange flags of the result path come in on a stub input. The block turns them, together with a missing-reference input, into the error bit. The coefficient-write strobe tells the register file which coefficient register (offset or full-scale) takes the calibration result. A register-port coefficient write is passed on only while the converter is stopped.

Top module: `adc_mode_seq`

## Requirements
- R1: After reset the status byte reads 0x88 (channel 0, reference present), ready is high, the mode is continuous (code 000) and the rate code is 1010. The first result therefore loads 2 x PERIOD_TAB[10] ticks after reset is released.
- R2: In continuous mode (000) the first data load comes two periods after a mode write, and each later load comes one period after the previous one. A configuration write while converting restarts the two-period count. Ready goes low on the cycle the data-load strobe is high.
- R3: While continuous mode has an unread result, ready goes high EARLY_TICKS ticks before the next update. A data read sets ready high on the cycle after the read.
- R4: Single mode (001) loads one result two periods after the write and switches the mode to power-down (011), which opens the power switch. Ready then stays low until a data read.
- R5: A calibration mode write sets ready high. Zero-scale (100) and system offset (110) each take 2 periods, system full-scale (111) takes 2 periods, and internal full-scale (101) takes 2 periods at gain code 000 and 4 periods at any other gain code. When a calibration ends, one coefficient-write strobe is issued with cal_sel_o = 0 for offset or 1 for full-scale, ready goes low and the mode becomes idle (010).
- R6: An internal full-scale calibration requested at gain code 111 is refused: the mode becomes idle, ready is high and no coefficient-write strobe follows.
- R7: Any mode write sets ready high and restarts the period count. Entering power-down (011) by a write opens the power switch (psw_en_o low) whatever the power-switch request.
- R8: The error bit (status bit 6) changes only when a result is loaded. It then takes the OR of overrange, underrange and missing reference. A write of continuous or single mode clears it.
- R9: A mode write with rate code 0000 keeps the rate that was in force before the write.
- R10: coef_wr_o follows coef_wr_i only while the mode is idle (010) or power-down (011), and is low otherwise.
- R11: Status byte layout: bit 7 ready, bit 6 error, bit 5 missing-reference input, bit 4 zero, bit 3 the ID_BIT parameter, bits 2..0 the channel input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Clock enable for the period timer |
| mode_wr_i | input | 1 | Mode register write strobe |
| mode_code_i | input | 3 | Operating mode carried by the write |
| rate_code_i | input | 4 | Update-rate code carried by the write |
| psw_i | input | 1 | Power-switch request carried by the write |
| cfg_wr_i | input | 1 | Configuration or IO register write strobe |
| gain_i | input | 3 | Current gain code (000 = unity, 111 = top gain) |
| chan_i | input | 3 | Active channel |
| ref_missing_i | input | 1 | Reference missing |
| res_over_i | input | 1 | Result overrange flag |
| res_under_i | input | 1 | Result underrange flag |
| data_rd_i | input | 1 | Data register read strobe |
| coef_wr_i | input | 1 | Coefficient write request from the register port |
| rdy_o | output | 1 | Ready, active low |
| status_o | output | 8 | Status byte |
| data_load_o | output | 1 | Data register load strobe |
| cal_wr_o | output | 1 | Calibration coefficient write strobe |
| cal_sel_o | output | 1 | Coefficient target: 0 offset, 1 full-scale |
| coef_wr_o | output | 1 | Gated coefficient write |
| psw_en_o | output | 1 | Power switch closed |
| mode_o | output | 3 | Mode in force |

## Verification
Errors in the period counter or in the remaining-period count show up as a load strobe or coefficient strobe in the wrong cycle. The scoreboard catches this within one period, because it compares the cycle of every strobe with a cycle worked out from the table. A wrong mode transition shows up at once on mode_o and psw_en_o, and a stale ready or error flag shows on the status byte in the cycle after the event that should have changed it. Refused calibrations and gated coefficient writes are checked by watching that no strobe appears.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [2:0] {
    MD_CONT    = 3'd0,
    MD_SINGLE  = 3'd1,
    MD_IDLE    = 3'd2,
    MD_PDOWN   = 3'd3,
    MD_ZS_CAL  = 3'd4,
    MD_FS_CAL  = 3'd5,
    MD_SYS_OFS = 3'd6,
    MD_SYS_FS  = 3'd7
  } seq_mode_e;

  localparam logic [2:0] GAIN_UNITY = 3'd0;
  localparam logic [2:0] GAIN_TOP   = 3'd7;
  localparam logic [2:0] SETTLE_PERIODS  = 3'd2;
  localparam logic [2:0] FS_HIGH_PERIODS = 3'd4;
endpackage

// File: rtl/adc_seq_rate_lut.sv
module adc_seq_rate_lut #(
  parameter int unsigned TICK_W = 16,
  parameter int unsigned PERIOD_TAB [0:15] = '{4, 8, 12, 16, 20, 24, 28, 32,
                                               36, 40, 44, 48, 52, 56, 60, 64}
) (
  input  logic [3:0]        rate_i,
  output logic [TICK_W-1:0] period_o
);
  logic [TICK_W-1:0] tab [16];

  for (genvar g = 0; g < 16; g++) begin : g_tab
    assign tab[g] = TICK_W'(PERIOD_TAB[g]);
  end

  assign period_o = tab[rate_i];
endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
  parameter int unsigned TICK_W      = 16,
  parameter int unsigned EARLY_TICKS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic              run_i,
  input  logic              tick_i,
  input  logic [TICK_W-1:0] period_i,
  output logic              end_o,
  output logic              early_o
);
  logic [TICK_W-1:0] cnt_q;
  logic              step;
  logic              last;

  assign step    = run_i & tick_i;
  assign last    = (cnt_q == period_i - TICK_W'(1));
  assign end_o   = step & last;
  assign early_o = step & (cnt_q == period_i - TICK_W'(EARLY_TICKS + 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (step)      cnt_q <= last ? '0 : cnt_q + TICK_W'(1);
  end
endmodule

// File: rtl/adc_mode_seq.sv
module adc_mode_seq
  import adc_seq_pkg::*;
#(
  parameter int unsigned TICK_W      = 16,
  parameter int unsigned EARLY_TICKS = 2,
  parameter bit          ID_BIT      = 1'b1,
  parameter int unsigned PERIOD_TAB [0:15] = '{4, 8, 12, 16, 20, 24, 28, 32,
                                               36, 40, 44, 48, 52, 56, 60, 64}
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       mode_wr_i,
  input  logic [2:0] mode_code_i,
  input  logic [3:0] rate_code_i,
  input  logic       psw_i,
  input  logic       cfg_wr_i,
  input  logic [2:0] gain_i,
  input  logic [2:0] chan_i,
  input  logic       ref_missing_i,
  input  logic       res_over_i,
  input  logic       res_under_i,
  input  logic       data_rd_i,
  input  logic       coef_wr_i,
  output logic       rdy_o,
  output logic [7:0] status_o,
  output logic       data_load_o,
  output logic       cal_wr_o,
  output logic       cal_sel_o,
  output logic       coef_wr_o,
  output logic       psw_en_o,
  output logic [2:0] mode_o
);
  localparam logic [3:0] RATE_RST = 4'd10;

  seq_mode_e         mode_q;
  logic [3:0]        rate_q;
  logic [2:0]        left_q;
  logic              psw_q, rdy_q, err_q, load_q, calwr_q, calsel_q;
  logic [TICK_W-1:0] period;
  logic              per_end, per_early;
  logic              running, converting, cfg_restart, restart;
  logic [3:0]        wr_rate;
  seq_mode_e         wr_mode;
  logic              res_bad;

  assign converting  = (mode_q == MD_CONT) || (mode_q == MD_SINGLE);
  assign running     = converting || mode_q[2];
  assign cfg_restart = cfg_wr_i && converting;
  assign restart     = mode_wr_i || cfg_restart;
  assign wr_rate     = (rate_code_i == 4'd0) ? rate_q : rate_code_i;
  assign wr_mode     = seq_mode_e'(mode_code_i);
  assign res_bad     = res_over_i | res_under_i | ref_missing_i;

  adc_seq_rate_lut #(
    .TICK_W    (TICK_W),
    .PERIOD_TAB(PERIOD_TAB)
  ) u_lut (
    .rate_i  (rate_q),
    .period_o(period)
  );

  adc_seq_timer #(
    .TICK_W     (TICK_W),
    .EARLY_TICKS(EARLY_TICKS)
  ) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(restart),
    .run_i    (running),
    .tick_i   (tick_i),
    .period_i (period),
    .end_o    (per_end),
    .early_o  (per_early)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= MD_CONT;
      rate_q   <= RATE_RST;
      left_q   <= SETTLE_PERIODS;
      psw_q    <= 1'b0;
      rdy_q    <= 1'b1;
      err_q    <= 1'b0;
      load_q   <= 1'b0;
      calwr_q  <= 1'b0;
      calsel_q <= 1'b0;
    end else begin
      load_q  <= 1'b0;
      calwr_q <= 1'b0;
      if (mode_wr_i) begin
        rate_q <= wr_rate;
        psw_q  <= psw_i;
        rdy_q  <= 1'b1;
        left_q <= SETTLE_PERIODS;
        mode_q <= wr_mode;
        unique case (wr_mode)
          MD_CONT, MD_SINGLE: err_q <= 1'b0;
          MD_FS_CAL: begin
            if (gain_i == GAIN_TOP) mode_q <= MD_IDLE;   // refused
            else if (gain_i != GAIN_UNITY) left_q <= FS_HIGH_PERIODS;
          end
          default: ;
        endcase
      end else if (cfg_restart) begin
        rdy_q  <= 1'b1;
        left_q <= SETTLE_PERIODS;
      end else begin
        if (data_rd_i) rdy_q <= 1'b1;
        if (per_end) begin
          if (left_q > 3'd1) begin
            left_q <= left_q - 3'd1;
          end else if (converting) begin
            load_q <= 1'b1;
            rdy_q  <= 1'b0;
            err_q  <= res_bad;
            if (mode_q == MD_SINGLE) mode_q <= MD_PDOWN;
          end else begin
            calwr_q  <= 1'b1;
            calsel_q <= mode_q[0];
            rdy_q    <= 1'b0;
            mode_q   <= MD_IDLE;
          end
        end else if (per_early && left_q == 3'd1 && mode_q == MD_CONT) begin
          rdy_q <= 1'b1;   // warn before an unread result is replaced
        end
      end
    end
  end

  assign rdy_o       = rdy_q;
  assign status_o    = {rdy_q, err_q, ref_missing_i, 1'b0, ID_BIT, chan_i};
  assign data_load_o = load_q;
  assign cal_wr_o    = calwr_q;
  assign cal_sel_o   = calsel_q;
  assign coef_wr_o   = coef_wr_i && (mode_q == MD_IDLE || mode_q == MD_PDOWN);
  assign psw_en_o    = psw_q && (mode_q != MD_PDOWN);
  assign mode_o      = mode_q;
endmodule

// File: rtl/adc_mode_seq_chk.sv
module adc_mode_seq_chk
  import adc_seq_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       mode_wr_i,
  input logic       rdy_o,
  input logic [7:0] status_o,
  input logic       data_load_o,
  input logic       cal_wr_o,
  input logic       coef_wr_o,
  input logic [2:0] mode_o
);
  AST_LOAD_DROPS_RDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_load_o |-> !rdy_o); // R2

  AST_WRITE_RAISES_RDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_wr_i |=> rdy_o); // R7

  AST_SINGLE_TO_PDOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_load_o && $past(mode_o) == MD_SINGLE) |-> mode_o == MD_PDOWN); // R4

  AST_CAL_ENDS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_wr_o |-> (mode_o == MD_IDLE && !rdy_o)); // R5

  AST_ERR_ON_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[6]) |-> data_load_o); // R8

  AST_COEF_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coef_wr_o |-> (mode_o == MD_IDLE || mode_o == MD_PDOWN)); // R10
endmodule

bind adc_mode_seq adc_mode_seq_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mode_wr_i  (mode_wr_i),
  .rdy_o      (rdy_o),
  .status_o   (status_o),
  .data_load_o(data_load_o),
  .cal_wr_o   (cal_wr_o),
  .coef_wr_o  (coef_wr_o),
  .mode_o     (mode_o)
);

// File: tb/adc_mode_seq_test.sv
module adc_mode_seq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic       mode_wr = 1'b0;
  logic [2:0] mode_code = 3'd0;
  logic [3:0] rate_code = 4'd0;
  logic       psw = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [2:0] gain = 3'd0;
  logic [2:0] chan = 3'd0;
  logic       ref_missing = 1'b0;
  logic       over = 1'b0;
  logic       under = 1'b0;
  logic       data_rd = 1'b0;
  logic       coef_wr = 1'b0;
  logic       rdy, data_load, cal_wr, cal_sel, coef_wr_o, psw_en;
  logic [7:0] status;
  logic [2:0] mode;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;

  typedef struct {int kind; int at; int req;} exp_t;
  exp_t sb_q[$];

  localparam int P1 = 8;     // ticks for rate code 0001
  localparam int PDEF = 44;  // ticks for rate code 1010

  adc_mode_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .mode_wr_i(mode_wr),
    .mode_code_i(mode_code), .rate_code_i(rate_code), .psw_i(psw),
    .cfg_wr_i(cfg_wr), .gain_i(gain), .chan_i(chan),
    .ref_missing_i(ref_missing), .res_over_i(over), .res_under_i(under),
    .data_rd_i(data_rd), .coef_wr_i(coef_wr), .rdy_o(rdy),
    .status_o(status), .data_load_o(data_load), .cal_wr_o(cal_wr),
    .cal_sel_o(cal_sel), .coef_wr_o(coef_wr_o), .psw_en_o(psw_en),
    .mode_o(mode)
  );

  always #2 clk = ~clk;

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic expect_ev(input int kind, input int at, input int req);
    exp_t e;
    e.kind = kind; e.at = at; e.req = req;
    sb_q.push_back(e);
  endtask

  // kind: 0 data load, 1 offset coefficient, 2 full-scale coefficient
  always @(negedge clk) begin
    if (rst_n && (data_load || cal_wr)) begin
      int k;
      exp_t e;
      k = data_load ? 0 : (cal_sel ? 2 : 1);
      n_chk++;
      if (sb_q.size() == 0) begin
        n_fail++;
        $display("FAIL R%0d unexpected strobe: actual kind %0d at %0d expected none",
                 (k == 0) ? 2 : 6, k, cyc);
      end else begin
        e = sb_q.pop_front();
        if (e.kind != k || e.at != cyc) begin
          n_fail++;
          $display("FAIL R%0d strobe: actual kind %0d at %0d expected kind %0d at %0d",
                   e.req, k, cyc, e.kind, e.at);
        end
      end
    end
  end

  task automatic wait_to(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic write_mode(input logic [2:0] m, input logic [3:0] r,
                            input logic p, output int w);
    mode_code = m; rate_code = r; psw = p; mode_wr = 1'b1;
    w = cyc + 1;
    @(negedge clk);
    mode_wr = 1'b0;
  endtask

  initial begin
    int w, w2, c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check(status == 8'h88, "R1", "status after reset", status, 8'h88);
    check(rdy == 1'b1, "R1", "ready after reset", rdy, 1);
    check(mode == 3'd0, "R1", "mode after reset", mode, 0);
    expect_ev(0, 2 * PDEF, 1);         // R1 default rate
    expect_ev(0, 3 * PDEF, 2);         // R2 one period later
    wait_to(3 * PDEF - 3);
    check(rdy == 1'b0, "R3", "ready before early window", rdy, 0);
    wait_to(3 * PDEF - 2);
    check(rdy == 1'b1, "R3", "ready early rise", rdy, 1);
    wait_to(3 * PDEF);
    check(rdy == 1'b0, "R2", "ready low at load", rdy, 0);
    wait_to(3 * PDEF + 1);
    data_rd = 1'b1;
    @(negedge clk);
    data_rd = 1'b0;
    check(rdy == 1'b1, "R3", "ready after read", rdy, 1);

    // R8 error from overrange, R2 fast rate
    over = 1'b1;
    write_mode(3'd0, 4'd1, 1'b0, w);
    expect_ev(0, w + 2 * P1, 2);
    expect_ev(0, w + 3 * P1, 2);
    wait_to(w + 2 * P1 + 1);
    check(status[6] == 1'b1, "R8", "error after overrange load", status[6], 1);
    wait_to(w + 3 * P1 + 1);
    over = 1'b0;
    write_mode(3'd0, 4'd0, 1'b0, w2);  // R9 reserved rate keeps 0001
    check(status[6] == 1'b0, "R8", "error cleared by write", status[6], 0);
    check(rdy == 1'b1, "R7", "ready after mode write", rdy, 1);
    expect_ev(0, w2 + 2 * P1, 9);
    wait_to(w2 + 2 * P1 + 2);
    cfg_wr = 1'b1;
    c = cyc + 1;
    @(negedge clk);
    cfg_wr = 1'b0;
    expect_ev(0, c + 2 * P1, 2);       // R2 restart by configuration write
    wait_to(c + 2 * P1 + 1);
    write_mode(3'd2, 4'd1, 1'b0, w);
    check(mode == 3'd2, "R7", "mode idle", mode, 2);

    // R4 single conversion
    write_mode(3'd1, 4'd1, 1'b1, w);
    check(psw_en == 1'b1, "R4", "switch closed while converting", psw_en, 1);
    expect_ev(0, w + 2 * P1, 4);
    wait_to(w + 2 * P1);
    check(mode == 3'd3, "R4", "mode after single", mode, 3);
    check(rdy == 1'b0, "R4", "ready after single", rdy, 0);
    check(psw_en == 1'b0, "R4", "switch open after single", psw_en, 0);
    wait_to(w + 2 * P1 + 14);
    check(rdy == 1'b0, "R4", "ready held low", rdy, 0);
    coef_wr = 1'b1;
    #1 check(coef_wr_o == 1'b1, "R10", "coef write in power-down", coef_wr_o, 1);
    coef_wr = 1'b0;
    data_rd = 1'b1;
    @(negedge clk);
    data_rd = 1'b0;
    check(rdy == 1'b1, "R4", "ready after read", rdy, 1);

    // R7 power-down by write
    write_mode(3'd0, 4'd1, 1'b1, w);
    check(psw_en == 1'b1, "R7", "switch closed in continuous", psw_en, 1);
    coef_wr = 1'b1;
    #1 check(coef_wr_o == 1'b0, "R10", "coef write blocked", coef_wr_o, 0);
    coef_wr = 1'b0;
    expect_ev(0, w + 2 * P1, 2);
    wait_to(w + 2 * P1 + 1);
    write_mode(3'd3, 4'd1, 1'b1, w);
    check(rdy == 1'b1, "R7", "ready in power-down", rdy, 1);
    check(psw_en == 1'b0, "R7", "switch open in power-down", psw_en, 0);
    check(mode == 3'd3, "R7", "mode power-down", mode, 3);

    // R5 calibrations
    gain = 3'd3;
    write_mode(3'd4, 4'd1, 1'b0, w);
    check(rdy == 1'b1 && mode == 3'd4, "R5", "zero-scale start", {rdy, mode}, 4'hC);
    expect_ev(1, w + 2 * P1, 5);
    wait_to(w + 2 * P1);
    check(rdy == 1'b0 && mode == 3'd2, "R5", "zero-scale end", {rdy, mode}, 4'h2);
    coef_wr = 1'b1;
    #1 check(coef_wr_o == 1'b1, "R10", "coef write in idle", coef_wr_o, 1);
    coef_wr = 1'b0;
    write_mode(3'd5, 4'd1, 1'b0, w);   // gain code 3: four periods
    expect_ev(2, w + 4 * P1, 5);
    wait_to(w + 4 * P1 + 1);
    gain = 3'd0;
    write_mode(3'd5, 4'd1, 1'b0, w);   // unity gain: two periods
    expect_ev(2, w + 2 * P1, 5);
    wait_to(w + 2 * P1 + 1);
    gain = 3'd3;
    write_mode(3'd6, 4'd1, 1'b0, w);
    expect_ev(1, w + 2 * P1, 5);
    wait_to(w + 2 * P1 + 1);
    write_mode(3'd7, 4'd1, 1'b0, w);
    expect_ev(2, w + 2 * P1, 5);
    wait_to(w + 2 * P1);
    check(cal_sel == 1'b1, "R5", "full-scale target", cal_sel, 1);
    @(negedge clk);

    // R6 refused internal full-scale at top gain
    gain = 3'd7;
    write_mode(3'd5, 4'd1, 1'b0, w);
    check(mode == 3'd2 && rdy == 1'b1, "R6", "refused calibration", {rdy, mode}, 4'hA);
    wait_to(w + 5 * P1);
    check(mode == 3'd2 && rdy == 1'b1, "R6", "no calibration ran", {rdy, mode}, 4'hA);
    gain = 3'd0;

    // R11 status layout
    ref_missing = 1'b1;
    chan = 3'd5;
    #1 check(status == 8'hAD, "R11", "status layout", status, 8'hAD);
    write_mode(3'd0, 4'd1, 1'b0, w);
    expect_ev(0, w + 2 * P1, 8);
    wait_to(w + 2 * P1);
    check(status[6] == 1'b1, "R8", "error from missing reference", status[6], 1);
    @(negedge clk);
    write_mode(3'd2, 4'd1, 1'b0, w);
    repeat (4) @(negedge clk);
    check(sb_q.size() == 0, "R2", "all expected strobes seen", sb_q.size(), 0);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule